// File: doc/BRIEF.md
# Look-Ahead Pipelined Eight-Sample Averaging Filter

This block is a streaming low-pass filter for sampled physiological signals such as an ECG trace, where it suppresses high-frequency noise. Each accepted input sample is a signed word marked by a valid flag. The block returns the mean of the eight most recent accepted samples, with its own valid flag, a fixed number of clocks later.

The filter keeps a running sum instead of adding all eight taps on every sample. On each accepted sample the sum gains the new value and loses the value that leaves the window. That recursion is unrolled two steps ahead, so the sum is updated from the value two samples back. The feedback loop therefore holds two registers and can be retimed for a higher clock rate. The output sequence is the plain eight-sample average, delayed.

Between taking a sample and computing the next window difference there is a pipeline register, and a second one sits between the sum and the scaled output. Scaling is an arithmetic right shift by the base-2 logarithm of the tap count. A parameter selects either floor division or round-half-up.

Top module: `malf_filter`

## Requirements
- R1: For each accepted sample, `out_data` equals the sum of the last eight accepted samples shifted arithmetically right by 3, with the shift rounding toward minus infinity. The sum is taken over the new sample and the seven accepted before it, and this holds when `ROUND_MODE` is `RND_FLOOR`.
- R2: `out_valid` is high in the clock cycle exactly four rising edges after the edge that sampled `in_valid` high. It is high in no other cycle, so there is one output per accepted sample, in order.
- R3: A cycle with `in_valid` low changes neither the sample history nor the running sum. Later outputs are the same as if the idle cycles had been removed.
- R4: After synchronous reset (`rst` high), `out_valid` is 0 and `out_data` is 0. The history counts as all zeros, so the first seven outputs average the accepted samples padded with zeros.
- R5: `out_data` keeps its value in every cycle in which `out_valid` is low.
- R6: With `ROUND_MODE` = `RND_HALF_UP`, `out_data` equals (sum + 4) shifted arithmetically right by 3, for negative and positive sums alike.
- R7: Full-scale input does not wrap. Eight samples of 32767 give 32767, and eight samples of -32768 give -32768, for `DATA_W` = 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | High when `in_data` carries a sample to accept |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | High for one cycle per averaged result |
| out_data | output | DATA_W | Signed averaged sample |

## Verification
The embedded properties check the following on every cycle:
- the four-cycle valid alignment in both directions;
- that idle cycles freeze the sample history;
- that the output holds between results;
- that the window difference and the running sum stay inside the ranges that true input values allow.

Whether the values are correct can only be shown by the bench's scenarios. Those are a step, randomly placed idle cycles, both full-scale rails and small signed values that exercise rounding. In each, every result is compared with a direct eight-sample sum, so only the scenarios show that the two-step recursion reproduces the plain average.

// File: rtl/malf_pkg.sv
package malf_pkg;

  // Choice of how the scaled sum is reduced to the output width.
  typedef enum logic {
    RND_FLOOR   = 1'b0,
    RND_HALF_UP = 1'b1
  } rnd_mode_e;

  // Number of steps the running-sum recursion is unrolled ahead.
  localparam int LA_STEPS = 2;

endpackage

// File: rtl/malf_history.sv
module malf_history #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 8,
  parameter int LA     = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        shift_en,
  input  logic signed [DATA_W-1:0]    din,
  output logic [LA-1:0][DATA_W-1:0]   fresh,
  output logic [LA-1:0][DATA_W-1:0]   stale
);
  localparam int DEPTH = TAPS + LA;

  logic [DEPTH-1:0][DATA_W-1:0] line_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_tap
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)           line_q[g] <= '0;
        else if (shift_en) line_q[g] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)           line_q[g] <= '0;
        else if (shift_en) line_q[g] <= line_q[g-1];
      end
    end
  end

  for (genvar k = 0; k < LA; k++) begin : g_pick
    assign fresh[k] = line_q[k];
    assign stale[k] = line_q[TAPS+k];
  end

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(line_q)) else $error("history moved on idle cycle"); // R3

endmodule

// File: rtl/malf_diff.sv
module malf_diff #(
  parameter int DATA_W = 16,
  parameter int LA     = 2,
  parameter int DIFF_W = 18
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load,
  input  logic [LA-1:0][DATA_W-1:0]   fresh,
  input  logic [LA-1:0][DATA_W-1:0]   stale,
  output logic signed [DIFF_W-1:0]    diff
);
  // Largest magnitude LA entering minus LA leaving samples can reach.
  localparam longint DIFF_LIM = longint'(LA) * ((longint'(1) <<< DATA_W) - 1);

  // Net change of the window sum over LA consecutive steps.
  function automatic logic signed [DIFF_W-1:0] window_delta(
    input logic [LA-1:0][DATA_W-1:0] enter,
    input logic [LA-1:0][DATA_W-1:0] leave
  );
    logic signed [DIFF_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < LA; i++) begin
      acc = acc + DIFF_W'($signed(enter[i])) - DIFF_W'($signed(leave[i]));
    end
    return acc;
  endfunction

  logic signed [DIFF_W-1:0] delta_c;
  assign delta_c = window_delta(fresh, stale);

  always_ff @(posedge clk) begin
    if (rst)       diff <= '0;
    else if (load) diff <= delta_c;
  end

  AST_DIFF_BOUND: assert property (@(posedge clk) disable iff (rst)
    (longint'(diff) <= DIFF_LIM) && (longint'(diff) >= -DIFF_LIM))
    else $error("window difference out of range"); // R7

endmodule

// File: rtl/malf_lookahead_acc.sv
module malf_lookahead_acc #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 8,
  parameter int LA     = 2,
  parameter int DIFF_W = 18,
  parameter int SUM_W  = 19
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      step,
  input  logic signed [DIFF_W-1:0]  diff,
  output logic signed [SUM_W-1:0]   sum
);
  localparam longint MAX_SUM = longint'(TAPS) * ((longint'(1) <<< (DATA_W-1)) - 1);

  // ring[0] holds sum[n-1], ring[LA-1] holds sum[n-LA] before a step.
  logic [LA-1:0][SUM_W-1:0] ring;

  function automatic logic signed [SUM_W-1:0] advance_sum(
    input logic signed [SUM_W-1:0]  older,
    input logic signed [DIFF_W-1:0] d
  );
    return older + SUM_W'(d);
  endfunction

  for (genvar g = 0; g < LA; g++) begin : g_loop
    if (g == 0) begin : g_newest
      always_ff @(posedge clk) begin
        if (rst)       ring[g] <= '0;
        else if (step) ring[g] <= advance_sum($signed(ring[LA-1]), diff);
      end
    end else begin : g_older
      always_ff @(posedge clk) begin
        if (rst)       ring[g] <= '0;
        else if (step) ring[g] <= ring[g-1];
      end
    end
  end

  assign sum = $signed(ring[0]);

  AST_SUM_BOUND: assert property (@(posedge clk) disable iff (rst)
    longint'(sum) <= MAX_SUM) else $error("running sum exceeds window maximum"); // R1

endmodule

// File: rtl/malf_scale.sv
module malf_scale #(
  parameter int                  DATA_W     = 16,
  parameter int                  SUM_W      = 19,
  parameter int                  SHIFT      = 3,
  parameter malf_pkg::rnd_mode_e ROUND_MODE = malf_pkg::RND_FLOOR
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic signed [SUM_W-1:0]   sum,
  output logic signed [DATA_W-1:0]  out_data,
  output logic                      out_valid
);
  logic signed [SUM_W-1:0] biased;

  if (ROUND_MODE == malf_pkg::RND_HALF_UP) begin : g_half_up
    localparam logic signed [SUM_W-1:0] BIAS = SUM_W'(1 <<< (SHIFT-1));
    assign biased = sum + BIAS;
  end else begin : g_floor
    assign biased = sum;
  end

  function automatic logic signed [DATA_W-1:0] shrink(input logic signed [SUM_W-1:0] s);
    logic signed [SUM_W-1:0] shifted;
    shifted = s >>> SHIFT;
    return shifted[DATA_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= load;
      if (load) out_data <= shrink(biased);
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(out_data)) else $error("output moved without a result"); // R5

endmodule

// File: rtl/malf_filter.sv
module malf_filter #(
  parameter int                  DATA_W     = 16,
  parameter int                  TAPS       = 8,
  parameter malf_pkg::rnd_mode_e ROUND_MODE = malf_pkg::RND_FLOOR
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic signed [DATA_W-1:0]  in_data,
  output logic                      out_valid,
  output logic signed [DATA_W-1:0]  out_data
);
  localparam int LA     = malf_pkg::LA_STEPS;
  localparam int SHIFT  = $clog2(TAPS);
  localparam int SUM_W  = DATA_W + SHIFT;
  localparam int DIFF_W = DATA_W + $clog2(LA) + 1;

  // Pipeline events, one per stage.
  logic line_shift;
  logic diff_load;
  logic sum_step;
  logic out_load;

  logic line_v, diff_v, sum_v;

  assign line_shift = in_valid;
  assign diff_load  = line_v;
  assign sum_step   = diff_v;
  assign out_load   = sum_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_v <= 1'b0;
      diff_v <= 1'b0;
      sum_v  <= 1'b0;
    end else begin
      line_v <= line_shift;
      diff_v <= diff_load;
      sum_v  <= sum_step;
    end
  end

  logic [LA-1:0][DATA_W-1:0] fresh, stale;
  logic signed [DIFF_W-1:0]  diff;
  logic signed [SUM_W-1:0]   sum;

  malf_history #(.DATA_W(DATA_W), .TAPS(TAPS), .LA(LA)) u_history (
    .clk(clk), .rst(rst), .shift_en(line_shift), .din(in_data),
    .fresh(fresh), .stale(stale)
  );

  malf_diff #(.DATA_W(DATA_W), .LA(LA), .DIFF_W(DIFF_W)) u_diff (
    .clk(clk), .rst(rst), .load(diff_load),
    .fresh(fresh), .stale(stale), .diff(diff)
  );

  malf_lookahead_acc #(.DATA_W(DATA_W), .TAPS(TAPS), .LA(LA),
                       .DIFF_W(DIFF_W), .SUM_W(SUM_W)) u_acc (
    .clk(clk), .rst(rst), .step(sum_step), .diff(diff), .sum(sum)
  );

  malf_scale #(.DATA_W(DATA_W), .SUM_W(SUM_W), .SHIFT(SHIFT),
               .ROUND_MODE(ROUND_MODE)) u_scale (
    .clk(clk), .rst(rst), .load(out_load), .sum(sum),
    .out_data(out_data), .out_valid(out_valid)
  );

  AST_LATENCY_FWD: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##4 out_valid) else $error("result missing after accept"); // R2

  AST_LATENCY_BACK: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 4)) else $error("result without accepted sample"); // R2

endmodule

// File: tb/malf_filter_bench.sv
module malf_filter_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [W-1:0] in_data = '0;
  logic out_valid, out_valid_r;
  logic signed [W-1:0] out_data, out_data_r;

  always #2 clk = ~clk;

  malf_filter #(.DATA_W(W), .TAPS(8), .ROUND_MODE(malf_pkg::RND_FLOOR)) u_malf_filter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  malf_filter #(.DATA_W(W), .TAPS(8), .ROUND_MODE(malf_pkg::RND_HALF_UP)) u_malf_filter_rnd (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid_r), .out_data(out_data_r)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int hist[8];
  int q_floor[$];
  int q_rnd[$];
  int q_cyc[$];
  string q_tag[$];
  int last_floor = 0;
  int last_rnd   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int floor_avg(int s);
    return s >>> 3;
  endfunction

  function automatic int half_up_avg(int s);
    return (s + 4) >>> 3;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(bit v, int x, string tag);
    int s;
    @(negedge clk);
    in_valid = v;
    in_data  = W'(x);
    if (v) begin
      for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = x;
      s = 0;
      for (int i = 0; i < 8; i++) s += hist[i];
      q_floor.push_back(floor_avg(s));
      q_rnd.push_back(half_up_avg(s));
      q_cyc.push_back(cyc + 4);
      q_tag.push_back(tag);
    end
  endtask

  // Output monitor, away from the rising edge.
  always @(negedge clk) begin
    if (!rst) begin
      check(out_valid_r == out_valid, "R2", int'(out_valid_r), int'(out_valid));
      if (q_cyc.size() > 0 && q_cyc[0] < cyc) begin
        check(1'b0, "R2", cyc, q_cyc[0]);
        void'(q_floor.pop_front()); void'(q_rnd.pop_front());
        void'(q_cyc.pop_front());   void'(q_tag.pop_front());
      end
      if (out_valid) begin
        if (q_cyc.size() == 0) begin
          check(1'b0, "R2", 1, 0);
        end else begin
          check(q_cyc[0] == cyc, "R2", cyc, q_cyc[0]);
          check(int'(out_data) == q_floor[0], q_tag[0], int'(out_data), q_floor[0]);
          check(int'(out_data_r) == q_rnd[0], "R6", int'(out_data_r), q_rnd[0]);
          last_floor = int'(out_data);
          last_rnd   = int'(out_data_r);
          void'(q_floor.pop_front()); void'(q_rnd.pop_front());
          void'(q_cyc.pop_front());   void'(q_tag.pop_front());
        end
      end else begin
        check(int'(out_data) == last_floor, "R5", int'(out_data), last_floor);
        check(int'(out_data_r) == last_rnd, "R5", int'(out_data_r), last_rnd);
      end
    end
  end

  initial begin
    void'($urandom(32'd20211222));
    for (int i = 0; i < 8; i++) hist[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R4: reset state at the ports
    check(out_valid == 1'b0, "R4", int'(out_valid), 0);
    check(int'(out_data) == 0, "R4", int'(out_data), 0);
    check(int'(out_data_r) == 0, "R4", int'(out_data_r), 0);

    // R4 then R1: step input, zero-padded ramp then steady value
    for (int i = 0; i < 12; i++) drive(1'b1, 1000, (i < 7) ? "R4" : "R1");
    // R1: signed step down
    for (int i = 0; i < 10; i++) drive(1'b1, -777, "R1");

    // R3: random samples with idle cycles scattered between them
    for (int i = 0; i < 400; i++) begin
      drive(($urandom % 3) != 0, int'($urandom % 65536) - 32768, "R3");
    end

    // R7: both full-scale rails
    for (int i = 0; i < 10; i++) drive(1'b1, 32767, "R7");
    for (int i = 0; i < 10; i++) drive(1'b1, -32768, "R7");

    // R6: small signed values exercising rounding boundaries
    for (int i = 0; i < 120; i++) drive(1'b1, int'($urandom % 27) - 13, "R6");

    for (int i = 0; i < 8; i++) drive(1'b0, 0, "R2");
    @(negedge clk);
    check(q_cyc.size() == 0, "R2", q_cyc.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule